// File: doc/BRIEF.md
# Channelized Synthesizer Frequency Word Generator

This block turns a set of frequency programming registers into the digital tuning words for a fractional-N synthesizer. Software programs a base frequency word, an 8-bit channel number and a channel-spacing term made of a mantissa and a two-bit exponent. The block adds the channel offset `chan * (256 + mant) * 2^(expo - 2)` to the base word. The result is in units of the reference clock divided by 2^16. The output carries two extra fractional bits, so it is actually in units of the reference divided by 2^18. Because of these two bits, exponents below 2 stay exact. The block also turns a 5-bit intermediate-frequency field into an IF word in the same units.

The registers sit behind a plain write port. A write is accepted only while the state input reports IDLE, which is code 0. Any write made in another state is dropped and sets a sticky error flag, which software clears by reading the status address. Both output words are registered, and each is recomputed on every clock from the stored fields. A change in any field therefore appears on the outputs exactly one clock after the write that made it.

The ports carry no stream traffic. Writes and reads are single-cycle strobes with no back-pressure. Read data is combinational from the stored state in the same cycle as `rd_en`.

Top module: `freqgen_top`

## Requirements
- R1: After reset every stored field is zero, `freq_word` and `if_word` are zero, and the status flag reads 0.
- R2: A write accepted at one clock edge changes `freq_word` and `if_word` only at the following edge. When no field changes, the output words hold their value.
- R3: A write with `wr_en` high while `state_i` is not 0 (IDLE is 0) changes no stored field, so the output words and read-back values do not change.
- R4: A rejected write sets the status flag, which is bit 0 at address 7. The flag holds until a read (`rd_en`) of address 7. That read returns 1, and the flag is 0 from the next cycle on. If a rejected write and a status read fall in the same cycle, the flag stays set.
- R5: `freq_word` equals 4*base + chan*(256+mant)*2^expo. Here base is the 24-bit word at addresses 0 (bits 7:0), 1 (bits 15:8) and 2 (bits 23:16), chan is at address 3, mant at address 4 and expo in bits 1:0 of address 5.
- R6: With chan = 0, `freq_word` equals base shifted left by two, whatever the spacing fields hold.
- R7: For expo = 0 and expo = 1, the two low bits of `freq_word` hold the fractional part of the offset exactly, with no rounding.
- R8: `if_word` equals the IF field (bits 4:0 of address 6) times 256.
- R9: Reading addresses 0 to 6 returns the stored fields, with the unused upper bits of addresses 5 and 6 read as 0. Bits 7:1 of address 7 read 0.
- R10: A write to address 7 in IDLE has no effect on any field or on the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_i | input | 3 | Radio state; 0 means IDLE |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 7 clears the status flag |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| freq_word | output | 27 | Synthesizer word in units of reference/2^18 |
| if_word | output | 13 | IF word in units of reference/2^18 |

## Verification
The hardest case to reach is the clash between clearing and setting the status flag: a rejected write and a status read must land in the same clock. The stimulus drives both strobes from one task at one falling edge, with a non-IDLE state, and then reads the status twice to show that the flag survived the clash. The one-cycle output latency is the other narrow window. It is checked by sampling `freq_word` at the falling edge right after the write edge, where the old value must still show, and again one cycle later. A behavioural model runs alongside and compares the outputs and read data on every clock.

// File: rtl/freqgen_pkg.sv
package freqgen_pkg;
  parameter int BASE_W  = 24;
  parameter int CHAN_W  = 8;
  parameter int MANT_W  = 8;
  parameter int EXP_W   = 2;
  parameter int IF_W    = 5;
  parameter int REG_W   = 8;
  parameter int ADDR_W  = 3;
  parameter int STATE_W = 3;

  localparam int FRAC_X     = 2;                        // extra fractional bits
  localparam int BASE_BYTES = BASE_W / REG_W;
  localparam int SPC_W      = MANT_W + 1;               // 256 + mantissa
  localparam int OFS_W      = CHAN_W + SPC_W + (2**EXP_W - 1);
  localparam int WORD_W     = BASE_W + FRAC_X + 1;
  localparam int IF_SH      = 16 + FRAC_X - 10;         // IF unit is ref/2^10
  localparam int IFO_W      = IF_W + IF_SH;

  localparam logic [STATE_W-1:0] ST_IDLE = '0;

  localparam logic [ADDR_W-1:0] A_CHAN = ADDR_W'(BASE_BYTES);
  localparam logic [ADDR_W-1:0] A_MANT = ADDR_W'(BASE_BYTES + 1);
  localparam logic [ADDR_W-1:0] A_EXPO = ADDR_W'(BASE_BYTES + 2);
  localparam logic [ADDR_W-1:0] A_IF   = ADDR_W'(BASE_BYTES + 3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_BYTES + 4);

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CHAN_W-1:0] chan;
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  expo;
    logic [IF_W-1:0]   ifw;
  } cfg_t;
endpackage

// File: rtl/freqgen_regs.sv
module freqgen_regs
  import freqgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  output cfg_t               cfg,
  output logic               err_q
);
  logic wr_ok, wr_rej, stat_rd;

  assign wr_ok   = wr_en && (state_i == ST_IDLE);
  assign wr_rej  = wr_en && (state_i != ST_IDLE);
  assign stat_rd = rd_en && (rd_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_ok) begin
      for (int k = 0; k < BASE_BYTES; k++) begin
        if (wr_addr == ADDR_W'(k)) cfg.base[k*REG_W +: REG_W] <= wr_data;
      end
      if (wr_addr == A_CHAN) cfg.chan <= wr_data[CHAN_W-1:0];
      if (wr_addr == A_MANT) cfg.mant <= wr_data[MANT_W-1:0];
      if (wr_addr == A_EXPO) cfg.expo <= wr_data[EXP_W-1:0];
      if (wr_addr == A_IF)   cfg.ifw  <= wr_data[IF_W-1:0];
    end
  end

  // sticky reject flag; a set in the same cycle beats the read clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (wr_rej)  err_q <= 1'b1;
    else if (stat_rd) err_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < BASE_BYTES; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_data = cfg.base[k*REG_W +: REG_W];
    end
    if (rd_addr == A_CHAN) rd_data = REG_W'(cfg.chan);
    if (rd_addr == A_MANT) rd_data = REG_W'(cfg.mant);
    if (rd_addr == A_EXPO) rd_data = REG_W'(cfg.expo);
    if (rd_addr == A_IF)   rd_data = REG_W'(cfg.ifw);
    if (rd_addr == A_STAT) rd_data = REG_W'(err_q);
  end
endmodule

// File: rtl/freqgen_offset.sv
module freqgen_offset
  import freqgen_pkg::*;
(
  input  logic [CHAN_W-1:0] chan,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic [OFS_W-1:0]  ofs
);
  logic [SPC_W-1:0] spc;
  logic [OFS_W-1:0] pp [CHAN_W];
  logic [OFS_W-1:0] prod;

  assign spc = {1'b1, mant};   // 256 + mantissa

  // shift-add partial products, one per channel bit
  for (genvar i = 0; i < CHAN_W; i++) begin : g_pp
    assign pp[i] = chan[i] ? (OFS_W'(spc) << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < CHAN_W; i++) prod = prod + pp[i];
  end

  // 2^(expo-2) with two fractional bits carried = plain shift by expo
  assign ofs = prod << expo;
endmodule

// File: rtl/freqgen_word.sv
module freqgen_word
  import freqgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [IF_W-1:0]   ifw,
  output logic [WORD_W-1:0] freq_word,
  output logic [IFO_W-1:0]  if_word
);
  logic [WORD_W-1:0] base_x;

  assign base_x = WORD_W'(base) << FRAC_X;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_word <= '0;
      if_word   <= '0;
    end else begin
      freq_word <= base_x + WORD_W'(ofs);
      if_word   <= IFO_W'(ifw) << IF_SH;
    end
  end
endmodule

// File: rtl/freqgen_top.sv
module freqgen_top
  import freqgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  output logic [WORD_W-1:0]  freq_word,
  output logic [IFO_W-1:0]   if_word
);
  cfg_t             cfg;
  logic             err_q;
  logic [OFS_W-1:0] ofs;

  freqgen_regs u_regs (
    .clk(clk), .rst_n(rst_n), .state_i(state_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg(cfg), .err_q(err_q)
  );

  freqgen_offset u_ofs (
    .chan(cfg.chan), .mant(cfg.mant), .expo(cfg.expo), .ofs(ofs)
  );

  freqgen_word u_word (
    .clk(clk), .rst_n(rst_n), .base(cfg.base), .ofs(ofs), .ifw(cfg.ifw),
    .freq_word(freq_word), .if_word(if_word)
  );
endmodule

// File: rtl/freqgen_chk.sv
module freqgen_chk
  import freqgen_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [STATE_W-1:0] state_i,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input cfg_t               cfg,
  input logic               err_q,
  input logic [WORD_W-1:0]  freq_word
);
  logic rej, clr;
  assign rej = wr_en && (state_i != ST_IDLE);
  assign clr = rd_en && (rd_addr == A_STAT);

  assert_reject_keeps_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> $stable(cfg));

  assert_reject_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> err_q);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr) |=> err_q);

  assert_word_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg) |=> $stable(freq_word));

  assert_chan0_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.chan == '0) |=> (freq_word == (WORD_W'($past(cfg.base)) << FRAC_X)));
endmodule

bind freqgen_top freqgen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state_i(state_i), .wr_en(wr_en),
  .rd_en(rd_en), .rd_addr(rd_addr), .cfg(cfg), .err_q(err_q),
  .freq_word(freq_word)
);

// File: tb/freqgen_top_tb_top.sv
`timescale 1ns/1ps
module freqgen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  state_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [26:0] freq_word;
  logic [12:0] if_word;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  freqgen_top dut_i (
    .clk(clk), .rst_n(rst_n), .state_i(state_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .freq_word(freq_word), .if_word(if_word)
  );

  // behavioural reference model
  longint m_base, m_chan, m_mant, m_exp, m_if;
  bit     m_err;
  longint e_word, e_if;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_chan = 0; m_mant = 0; m_exp = 0; m_if = 0; m_err = 0;
      e_word = 0; e_if = 0;
    end else begin
      e_word = m_base * 4 + m_chan * (256 + m_mant) * (longint'(1) << m_exp);
      e_if   = m_if * 256;
      if (rd_en && rd_addr == 3'd7) m_err = 0;
      if (wr_en && state_i != 3'd0) m_err = 1;
      else if (wr_en) begin
        case (wr_addr)
          3'd0: m_base = (m_base & 64'hFFFF00) | longint'(wr_data);
          3'd1: m_base = (m_base & 64'hFF00FF) | (longint'(wr_data) << 8);
          3'd2: m_base = (m_base & 64'h00FFFF) | (longint'(wr_data) << 16);
          3'd3: m_chan = wr_data;
          3'd4: m_mant = wr_data;
          3'd5: m_exp  = wr_data % 4;
          3'd6: m_if   = wr_data % 32;
          default: ;
        endcase
      end
    end
  end

  function automatic longint exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_base % 256;
      3'd1: return (m_base >> 8) % 256;
      3'd2: return (m_base >> 16) % 256;
      3'd3: return m_chan;
      3'd4: return m_mant;
      3'd5: return m_exp;
      3'd6: return m_if;
      default: return longint'(m_err);
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 freq_word", longint'(freq_word), e_word);
      chk("R8 if_word", longint'(if_word), e_if);
      chk("R9 rd_data", longint'(rd_data), exp_rd(rd_addr));
    end
  end

  task automatic wr(input logic [2:0] st, input logic [2:0] a, input logic [7:0] d);
    state_i = st; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; state_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_base(input longint b);
    wr(3'd0, 3'd0, 8'(b));
    wr(3'd0, 3'd1, 8'(b >> 8));
    wr(3'd0, 3'd2, 8'(b >> 16));
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    longint old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 freq_word", longint'(freq_word), 0);
    chk("R1 if_word", longint'(if_word), 0);
    rd(3'd7, v); chk("R1 status", longint'(v), 0);
    rd(3'd2, v); chk("R1 base byte", longint'(v), 0);

    // R6 channel 0 maps to the base word
    wr(3'd0, 3'd4, 8'hC4);
    wr(3'd0, 3'd5, 8'h03);
    set_base(64'h5D1234);
    settle();
    chk("R6 chan0", longint'(freq_word), 64'h5D1234 * 4);

    // R2 latency: old value right after the write edge, new one a cycle later
    old = longint'(freq_word);
    wr(3'd0, 3'd3, 8'd10);
    chk("R2 before", longint'(freq_word), old);
    @(negedge clk);
    chk("R2 after", longint'(freq_word), 64'h5D1234 * 4 + 10 * (256 + 196) * 8);

    // R5 several spacings
    wr(3'd0, 3'd4, 8'h3B);
    wr(3'd0, 3'd5, 8'h02);
    settle();
    chk("R5 e2", longint'(freq_word), 64'h5D1234 * 4 + 10 * (256 + 59) * 4);
    wr(3'd0, 3'd3, 8'hFF);
    wr(3'd0, 3'd4, 8'hFF);
    wr(3'd0, 3'd5, 8'h03);
    settle();
    chk("R5 max", longint'(freq_word), 64'h5D1234 * 4 + 255 * 511 * 8);

    // R7 exact fractional bits for expo 0 and 1
    wr(3'd0, 3'd3, 8'd3);
    wr(3'd0, 3'd4, 8'd1);
    wr(3'd0, 3'd5, 8'd0);
    settle();
    chk("R7 e0", longint'(freq_word), 64'h5D1234 * 4 + 771);
    chk("R7 e0 frac", longint'(freq_word[1:0]), 3);
    wr(3'd0, 3'd5, 8'd1);
    settle();
    chk("R7 e1", longint'(freq_word), 64'h5D1234 * 4 + 1542);

    // R8 / R9 IF field and read-back masking
    wr(3'd0, 3'd6, 8'hFF);
    settle();
    chk("R8 if", longint'(if_word), 31 * 256);
    rd(3'd6, v); chk("R9 if mask", longint'(v), 8'h1F);
    wr(3'd0, 3'd5, 8'hFE);
    rd(3'd5, v); chk("R9 expo mask", longint'(v), 8'h02);

    // R3 rejected write leaves everything alone
    old = longint'(freq_word);
    wr(3'd2, 3'd3, 8'h77);
    settle();
    chk("R3 word", longint'(freq_word), old);
    rd(3'd3, v); chk("R3 chan", longint'(v), 3);

    // R4 sticky flag, cleared by a status read
    rd(3'd7, v); chk("R4 set", longint'(v), 1);
    rd(3'd7, v); chk("R4 cleared", longint'(v), 0);

    // R4 reject and status read in the same cycle: flag stays set
    state_i = 3'd5; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hAA;
    rd_en = 1'b1; rd_addr = 3'd7;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; state_i = '0;
    rd(3'd7, v); chk("R4 set wins", longint'(v), 1);
    rd(3'd7, v); chk("R4 clear again", longint'(v), 0);

    // R10 write to the status address in IDLE does nothing
    old = longint'(freq_word);
    wr(3'd0, 3'd7, 8'hFF);
    settle();
    chk("R10 word", longint'(freq_word), old);
    rd(3'd7, v); chk("R10 status", longint'(v), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule